// File: doc/BRIEF.md
# Branch-Likely Delay-Slot Sequencer

This block chooses the program counter for the next retire step of a simple in-order core that has branch delay slots. Each step it takes the decoded opcode, the two register operand values, the current PC and the low 26 bits of the instruction word. From these it produces the next PC, a flag showing that a branch target is waiting to be applied once the delay slot has retired, a squash strobe that cancels the delay-slot instruction, and a trap strobe for control-flow opcodes that are not implemented.

The ordinary equal and not-equal branches always let their delay slot run. When a branch or jump is taken, the block saves its target in a register. The following step, which is the delay slot, retires at PC+4, and the step after it starts at the saved target. The branch-likely-equal variant is taken under the same condition as the ordinary equal branch. When it is not taken, it cancels its slot: the next PC goes straight to PC+8 and no target is saved.

The surrounding core advances one instruction per asserted `stepEn`. The register file, the ALU, memory access and exception entry live elsewhere. The core feeds `nextPc` back as `pc` on the following step.

Top module: `branch_likely_seq`

## Requirements
- R1: After reset, `branchPending` is 0. The first step with a non-control-flow opcode gives `nextPc = pc + 4` with `squashSlot` and `trapUnimpl` at 0.
- R2: Opcode 6'h04 (equal branch) with `rsVal == rtVal` gives `nextPc = pc + 4` and raises `branchPending` after the edge. The next step then gives `nextPc = pc_branch + 4 + (sign-extended instrIdx[15:0] << 2)`.
- R3: Opcode 6'h04 with `rsVal != rtVal` gives `nextPc = pc + 4` with no squash and no pending target, so its delay slot runs.
- R4: Opcode 6'h05 (not-equal branch) is taken when `rsVal != rtVal`, using the same target rule and delay-slot timing as R2. When the operands are equal it falls through to `pc + 4`.
- R5: Opcode 6'h14 (branch-likely equal) with `rsVal == rtVal` behaves as in R2: the delay slot runs (`squashSlot` = 0), then control transfers to the target.
- R6: Opcode 6'h14 with `rsVal != rtVal` asserts `squashSlot` and gives `nextPc = pc + 8`, and `branchPending` stays 0 afterward.
- R7: Opcodes 6'h02 and 6'h03 (jumps) always arm a pending target of `{(pc+4)[31:28], instrIdx, 2'b00}`. That target is applied after one delay-slot step.
- R8: While `branchPending` is 1, the step's `nextPc` is the saved target, whatever the slot's opcode is. Control-flow opcodes in the slot neither arm a new target nor squash, and the flag clears after that step.
- R9: `trapUnimpl` is 1 for opcodes 6'h01, 6'h06, 6'h07, 6'h15, 6'h16 and 6'h17, and 0 for every other opcode, including 6'h14.
- R10: When `stepEn` is 0, the pending flag and the saved target keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | One instruction retires on this edge |
| opcode | input | 6 | Primary opcode of the retiring instruction |
| rsVal | input | 32 | First register operand |
| rtVal | input | 32 | Second register operand |
| pc | input | 32 | PC of the retiring instruction |
| instrIdx | input | 26 | Low 26 instruction bits (branch offset in [15:0]) |
| nextPc | output | 32 | PC for the following step |
| branchPending | output | 1 | A target waits to be applied after the delay slot |
| squashSlot | output | 1 | Delay-slot instruction is cancelled |
| trapUnimpl | output | 1 | Unimplemented control-flow opcode |

## Verification
The bench puts the two equal-type branches side by side with identical operands. A design that treated the likely form as ordinary would return PC+4 where PC+8 is expected and would never squash. A design that treated the ordinary form as likely would skip a slot that must run. A not-taken likely branch is followed by a plain step to catch a target that leaks out of the squash. A branch or jump placed in a delay slot checks that a design does not arm a second target there. Negative offsets expose a missing sign extension, and steps with `stepEn` low catch a pending flag that moves without a retire.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam logic [5:0] OP_REGIMM = 6'h01;
  localparam logic [5:0] OP_J      = 6'h02;
  localparam logic [5:0] OP_JAL    = 6'h03;
  localparam logic [5:0] OP_BEQ    = 6'h04;
  localparam logic [5:0] OP_BNE    = 6'h05;
  localparam logic [5:0] OP_BLEZ   = 6'h06;
  localparam logic [5:0] OP_BGTZ   = 6'h07;
  localparam logic [5:0] OP_BEQL   = 6'h14;
  localparam logic [5:0] OP_BNEL   = 6'h15;
  localparam logic [5:0] OP_BLEZL  = 6'h16;
  localparam logic [5:0] OP_BGTZL  = 6'h17;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REL  = 2'd1,
    TGT_ABS  = 2'd2
  } tgtSel_e;

  typedef struct packed {
    logic    armPending; // save a target for after the slot
    tgtSel_e tgtSel;     // which target to save
    logic    skipSlot;   // advance by two instructions
    logic    redirect;   // apply the saved target now
    logic    trap;       // unimplemented control-flow opcode
  } ctrlStrobe_t;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic        operandsEq,
  input  logic        pendingQ,
  output ctrlStrobe_t strb
);
  logic isUnimpl;

  always_comb begin
    isUnimpl = 1'b0;
    case (opcode)
      OP_REGIMM, OP_BLEZ, OP_BGTZ,
      OP_BNEL, OP_BLEZL, OP_BGTZL: isUnimpl = 1'b1;
      default:                     isUnimpl = 1'b0;
    endcase
  end

  always_comb begin
    strb            = '0;
    strb.tgtSel     = TGT_NONE;
    strb.trap       = isUnimpl;
    if (pendingQ) begin
      // delay slot retiring: control flow in the slot is not evaluated
      strb.redirect = 1'b1;
    end else begin
      case (opcode)
        OP_BEQ: if (operandsEq) begin
          strb.armPending = 1'b1;
          strb.tgtSel     = TGT_REL;
        end
        OP_BNE: if (!operandsEq) begin
          strb.armPending = 1'b1;
          strb.tgtSel     = TGT_REL;
        end
        OP_BEQL: if (operandsEq) begin
          strb.armPending = 1'b1;
          strb.tgtSel     = TGT_REL;
        end else begin
          strb.skipSlot   = 1'b1;
        end
        OP_J, OP_JAL: begin
          strb.armPending = 1'b1;
          strb.tgtSel     = TGT_ABS;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  input  logic [XLEN-1:0]  pc,
  input  logic [IDX_W-1:0] instrIdx,
  input  ctrlStrobe_t      strb,
  output logic             operandsEq,
  output logic             pendingQ,
  output logic [XLEN-1:0]  nextPc
);
  localparam int EXT_W  = XLEN - OFF_W - 2;
  localparam int HIGH_W = XLEN - IDX_W - 2;
  localparam logic [XLEN-1:0] STEP1 = XLEN'(4);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(8);

  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] pcPlus8;
  logic [XLEN-1:0] relOffset;
  logic [XLEN-1:0] relTarget;
  logic [XLEN-1:0] absTarget;
  logic [XLEN-1:0] newTarget;
  logic [XLEN-1:0] targetQ;

  assign operandsEq = (rsVal == rtVal);
  assign pcPlus4    = pc + STEP1;
  assign pcPlus8    = pc + STEP2;

  generate
    if (EXT_W > 0) begin : g_sext
      assign relOffset = {{EXT_W{instrIdx[OFF_W-1]}}, instrIdx[OFF_W-1:0], 2'b00};
    end else begin : g_trunc
      assign relOffset = XLEN'({instrIdx[OFF_W-1:0], 2'b00});
    end
  endgenerate

  assign relTarget = pcPlus4 + relOffset;
  assign absTarget = {pcPlus4[XLEN-1 -: HIGH_W], instrIdx, 2'b00};

  always_comb begin
    case (strb.tgtSel)
      TGT_REL: newTarget = relTarget;
      TGT_ABS: newTarget = absTarget;
      default: newTarget = pcPlus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      targetQ  <= '0;
    end else if (stepEn) begin
      if (strb.redirect) begin
        pendingQ <= 1'b0;
      end else if (strb.armPending) begin
        pendingQ <= 1'b1;
        targetQ  <= newTarget;
      end
    end
  end

  always_comb begin
    if (strb.redirect)      nextPc = targetQ;
    else if (strb.skipSlot) nextPc = pcPlus8;
    else                    nextPc = pcPlus4;
  end
endmodule

// File: rtl/branch_likely_seq.sv
module branch_likely_seq
  import bseq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic [5:0]       opcode,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  input  logic [XLEN-1:0]  pc,
  input  logic [IDX_W-1:0] instrIdx,
  output logic [XLEN-1:0]  nextPc,
  output logic             branchPending,
  output logic             squashSlot,
  output logic             trapUnimpl
);
  localparam int OFF_W = 16;

  ctrlStrobe_t strb;
  logic        operandsEq;
  logic        pendingQ;

  bseq_ctrl u_ctrl (
    .opcode     (opcode),
    .operandsEq (operandsEq),
    .pendingQ   (pendingQ),
    .strb       (strb)
  );

  bseq_datapath #(
    .XLEN  (XLEN),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .pc         (pc),
    .instrIdx   (instrIdx),
    .strb       (strb),
    .operandsEq (operandsEq),
    .pendingQ   (pendingQ),
    .nextPc     (nextPc)
  );

  assign branchPending = pendingQ;
  assign squashSlot    = strb.skipSlot;
  assign trapUnimpl    = strb.trap;
endmodule

// File: rtl/branch_likely_seq_chk.sv
module branch_likely_seq_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepEn,
  input logic [5:0]       opcode,
  input logic [XLEN-1:0]  rsVal,
  input logic [XLEN-1:0]  rtVal,
  input logic [XLEN-1:0]  pc,
  input logic [XLEN-1:0]  nextPc,
  input logic             branchPending,
  input logic             squashSlot,
  input logic             trapUnimpl
);
  AST_SQUASH_PC_PLUS8: assert property (@(posedge clk) disable iff (!rstN)
    squashSlot |-> (nextPc == pc + XLEN'(8))); // R6
  AST_SQUASH_NO_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && squashSlot) |=> !branchPending); // R6
  AST_SQUASH_NEEDS_BEQL_MISS: assert property (@(posedge clk) disable iff (!rstN)
    squashSlot |-> (opcode == 6'h14 && rsVal != rtVal && !branchPending)); // R6
  AST_BEQ_MISS_RUNS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (!branchPending && opcode == 6'h04 && rsVal != rtVal) |-> (!squashSlot && nextPc == pc + XLEN'(4))); // R3
  AST_SLOT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && branchPending) |=> !branchPending); // R8
  AST_SLOT_NO_SQUASH: assert property (@(posedge clk) disable iff (!rstN)
    branchPending |-> !squashSlot); // R8
  AST_BEQL_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == 6'h14) |-> !trapUnimpl); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(branchPending)); // R10
endmodule

bind branch_likely_seq branch_likely_seq_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .stepEn        (stepEn),
  .opcode        (opcode),
  .rsVal         (rsVal),
  .rtVal         (rtVal),
  .pc            (pc),
  .nextPc        (nextPc),
  .branchPending (branchPending),
  .squashSlot    (squashSlot),
  .trapUnimpl    (trapUnimpl)
);

// File: tb/branch_likely_seq_bench.sv
module branch_likely_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] pc = '0;
  logic [25:0] instrIdx = '0;
  logic [31:0] nextPc;
  logic        branchPending;
  logic        squashSlot;
  logic        trapUnimpl;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] nextPc;
    logic        pend;
    logic        squash;
    logic        trap;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;

  logic        mPend = 1'b0;
  logic [31:0] mTgt  = '0;
  logic [31:0] mPc   = 32'h0040_0000;

  always #10 clk = ~clk;

  branch_likely_seq u_branch_likely_seq (
    .clk           (clk),
    .rstN          (rstN),
    .stepEn        (stepEn),
    .opcode        (opcode),
    .rsVal         (rsVal),
    .rtVal         (rtVal),
    .pc            (pc),
    .instrIdx      (instrIdx),
    .nextPc        (nextPc),
    .branchPending (branchPending),
    .squashSlot    (squashSlot),
    .trapUnimpl    (trapUnimpl)
  );

  function automatic logic isUnimpl(input logic [5:0] op);
    return op == 6'h01 || op == 6'h06 || op == 6'h07 ||
           op == 6'h15 || op == 6'h16 || op == 6'h17;
  endfunction

  // Driver: apply one step, compute the expected result from the requirements.
  task automatic doStep(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [25:0] idx, input logic en, input string tag);
    expItem_t    it;
    logic        take;
    logic [31:0] tgt;
    @(negedge clk);
    opcode   = op;
    rsVal    = a;
    rtVal    = b;
    instrIdx = idx;
    pc       = mPc;
    stepEn   = en;
    take     = 1'b0;
    tgt      = '0;
    it.tag    = tag;
    it.pend   = mPend;
    it.squash = 1'b0;
    it.trap   = isUnimpl(op);
    it.nextPc = mPc + 32'd4;
    if (mPend) begin
      it.nextPc = mTgt;
    end else begin
      case (op)
        6'h04: take = (a == b);
        6'h05: take = (a != b);
        6'h14: begin
          take = (a == b);
          if (a != b) begin
            it.squash = 1'b1;
            it.nextPc = mPc + 32'd8;
          end
        end
        6'h02, 6'h03: take = 1'b1;
        default: take = 1'b0;
      endcase
      if (op == 6'h02 || op == 6'h03)
        tgt = {((mPc + 32'd4) >> 28), idx, 2'b00};
      else
        tgt = mPc + 32'd4 + {{14{idx[15]}}, idx[15:0], 2'b00};
    end
    expQ.push_back(it);
    #2 -> sampleEv;
    if (en) begin
      if (mPend) mPend = 1'b0;
      else if (take) begin
        mPend = 1'b1;
        mTgt  = tgt;
      end
      mPc = it.nextPc;
    end
  endtask

  // Monitor: pop the expected item and compare with the outputs.
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() != 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (nextPc !== e.nextPc || branchPending !== e.pend ||
            squashSlot !== e.squash || trapUnimpl !== e.trap) begin
          fails++;
          $display("FAIL %s: got pc=%h pend=%b sq=%b trap=%b, expected pc=%h pend=%b sq=%b trap=%b",
                   e.tag, nextPc, branchPending, squashSlot, trapUnimpl,
                   e.nextPc, e.pend, e.squash, e.trap);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (branchPending !== 1'b0) begin
      fails++;
      $display("FAIL R1: got pend=%b, expected pend=0", branchPending);
    end
    rstN = 1'b1;

    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R1");
    // R2: equal branch taken, forward offset, then delay slot and redirect
    doStep(6'h04, 32'h55, 32'h55, 26'h0010, 1'b1, "R2");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R2");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R2");
    // R3: equal branch not taken runs its slot, no pending
    doStep(6'h04, 32'h1, 32'h2, 26'h0010, 1'b1, "R3");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R3");
    // R4: not-equal taken with negative offset, then fall-through case
    doStep(6'h05, 32'h1, 32'h2, 26'h0FFF0, 1'b1, "R4");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R4");
    doStep(6'h05, 32'h7, 32'h7, 26'h0FFF0, 1'b1, "R4");
    // R5: likely branch taken keeps its slot
    doStep(6'h14, 32'hBEEF, 32'hBEEF, 26'h0020, 1'b1, "R5");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R5");
    // R6: likely branch not taken squashes, no stale target
    doStep(6'h14, 32'hBEEF, 32'hCAFE, 26'h0020, 1'b1, "R6");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R6");
    doStep(6'h04, 32'h3, 32'h4, 26'h0020, 1'b1, "R6");
    // R7/R8: jump, then a taken branch placed in its delay slot is ignored
    doStep(6'h02, 32'h0, 32'h0, 26'h123_4567, 1'b1, "R7");
    doStep(6'h04, 32'h9, 32'h9, 26'h0040, 1'b1, "R8");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R8");
    doStep(6'h03, 32'h0, 32'h0, 26'h000_0100, 1'b1, "R7");
    doStep(6'h14, 32'h1, 32'h2, 26'h0, 1'b1, "R8");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R8");
    // R9: unimplemented control-flow opcodes trap
    doStep(6'h01, 32'h0, 32'h0, 26'h0, 1'b1, "R9");
    doStep(6'h06, 32'h0, 32'h0, 26'h0, 1'b1, "R9");
    doStep(6'h07, 32'h0, 32'h0, 26'h0, 1'b1, "R9");
    doStep(6'h15, 32'h0, 32'h0, 26'h0, 1'b1, "R9");
    doStep(6'h16, 32'h0, 32'h0, 26'h0, 1'b1, "R9");
    doStep(6'h17, 32'h0, 32'h0, 26'h0, 1'b1, "R9");
    doStep(6'h14, 32'h5, 32'h5, 26'h0004, 1'b1, "R9");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R9");
    // R10: no step, state holds (both idle and pending)
    doStep(6'h04, 32'h8, 32'h8, 26'h0030, 1'b0, "R10");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R10");
    doStep(6'h05, 32'h8, 32'h9, 26'h0FF00, 1'b1, "R10");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b0, "R10");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R10");
    doStep(6'h00, 32'h0, 32'h0, 26'h0, 1'b1, "R10");

    @(negedge clk);
    stepEn = 1'b0;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule